// File: doc/BRIEF.md
# MDIO Management Interface Master

This block is the host-side master for the two-wire PHY management bus. Software composes a complete 32-bit clause-22 management frame (start, opcode, PHY address, register number, turnaround and data) and writes it into a data register through a simple single-cycle register port. The block then clocks out 32 idle ones as a preamble, followed by the frame most significant bit first. MDIO changes on the falling edge of MDC, and the PHY samples it on the rising edge.

When the frame's opcode marks a read, the block releases the MDIO line from the second turnaround bit onward. It samples the sixteen reply bits on the rising MDC edges of the data phase and writes them into the low half of the data register. At the end of every transaction a completion flag is raised in an event register, and software clears it by writing a one. A speed register sets the half-period of MDC in system clocks, so the MDC rate is the system clock divided by twice the speed value. Software must pick a value that keeps MDC at or below 2.5 MHz. A speed value of zero freezes MDC and pauses any transaction in flight. If a read returns all ones, no PHY answered at that address.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, MDC is low, MDIO output enable is low, MDIO output is high, and the data, event and speed registers all read zero. The register map is data at address 0, event at address 1 (completion flag in bit 0) and speed at address 2.
- R2: While a transaction runs with speed value S greater than zero, MDC is high for S system clocks and low for S system clocks, for a period of 2*S.
- R3: A write to the data register while idle starts a transaction. It sends 32 ones, then the written word from bit 31 down to bit 0, one bit per MDC period.
- R4: MDIO output changes only on a falling MDC edge, so it is stable across every rising edge.
- R5: When frame bits 29:28 are 10 (read), output enable drops from frame bit 16 (second turnaround bit) through bit 0. Any other opcode keeps output enable high for all 64 bits.
- R6: On a read, the MDIO input sampled at the rising MDC edges of frame bits 15 down to 0 is stored, first bit as the most significant, into data register bits 15:0 at completion. Bits 31:16 keep the written word.
- R7: At completion, MDC returns low and output enable drops, and event bit 0 is set. Writing 1 to it clears it; writing 0 leaves it set.
- R8: A write to the data register while a transaction is in progress is ignored. The register contents and the frame on the wire are unchanged.
- R9: A speed value of zero holds MDC at its level and pauses the transaction. Restoring a non-zero value resumes it with no bit lost or repeated.
- R10: A read from an address where no PHY drives MDIO (line pulled high) leaves 0xFFFF in data register bits 15:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO line input |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable, high when the master drives |

## Verification
The hardest situation to reach from the ports is a transaction that is paused in the middle of its frame by a zero speed value and then resumed. The stimulus first starts a frame at a non-zero speed and lets a number of bits pass. It then writes zero to the speed register and holds it for many clocks while watching that MDC does not move. It restores the speed afterwards, and the scoreboard compares all 64 observed line bits against the expected preamble and frame. A second hard case is a data-register write landing mid-frame. The stimulus issues it while the preamble is still shifting and later confirms that both the wire pattern and the register readback kept the first word.

// File: rtl/mdio_mgmt_pkg.sv
// Package: shared constants, register addresses and the per-bit line
// drive function for the MDIO management master.
// Assumes a 32-bit preamble of ones followed by a 32-bit clause-22 frame.
package mdio_mgmt_pkg;

    localparam int FRAME_W    = 32;
    localparam int PRE_LEN    = 32;
    localparam int SEQ_LEN    = PRE_LEN + FRAME_W;
    localparam int IDX_W      = $clog2(SEQ_LEN);
    localparam int REPLY_W    = 16;
    localparam int DATA_START = SEQ_LEN - REPLY_W;      // first reply bit index
    localparam int RELEASE_AT = DATA_START - 1;         // second turnaround bit
    localparam int OP_HI      = 29;
    localparam int ADDR_W     = 2;

    localparam logic [ADDR_W-1:0] ADR_DATA  = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_EVENT = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_SPEED = 2'd2;
    localparam logic [1:0]        OP_READ   = 2'b10;

    typedef struct packed {
        logic o;
        logic oe;
    } pin_drv_t;

    // Line value and enable for sequence position idx of frame frm.
    function automatic pin_drv_t drive_for(input logic [IDX_W-1:0] idx,
                                           input logic [FRAME_W-1:0] frm,
                                           input logic rd);
        pin_drv_t d;
        logic [IDX_W-1:0] rel;
        rel = IDX_W'(SEQ_LEN - 1) - idx;
        if (idx < IDX_W'(PRE_LEN)) begin
            d.o  = 1'b1;
            d.oe = 1'b1;
        end else if (rd && idx >= IDX_W'(RELEASE_AT)) begin
            d.o  = 1'b1;
            d.oe = 1'b0;
        end else begin
            d.o  = frm[rel[$clog2(FRAME_W)-1:0]];
            d.oe = 1'b1;
        end
        return d;
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
// MDC generator: while run is high and the speed value is non-zero, toggles
// MDC every SPEED system clocks and flags the cycles whose clock edge makes
// MDC rise or fall. Idle (run low) forces MDC low and clears the count.
// Assumes speed may change at any time; a shrinking value takes effect at once.
module mdio_mdc_gen #(
    parameter int SPD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SPD_W-1:0] speed,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);

    logic [SPD_W-1:0] cnt_q;
    logic             mdc_q;
    logic             tick;

    // Toggle point: count reached the half-period with a live speed value.
    always_comb begin
        tick = run && (speed != '0) && (cnt_q >= speed - SPD_W'(1));
    end

    // Half-period counter and MDC level register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else if (speed != '0) begin
            cnt_q <= cnt_q + SPD_W'(1);
        end
    end

    assign mdc      = mdc_q;
    assign rise_stb = tick && !mdc_q;
    assign fall_stb = tick &&  mdc_q;

endmodule

// File: rtl/mdio_frame_engine.sv
// Frame engine: walks a 64-position sequence (preamble then frame), updating
// the MDIO drive on each falling MDC edge and capturing reply bits on rising
// edges of a read's data phase. Pulses done on the final falling edge.
// Assumes start is only asserted while busy is low.
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    input  logic               rise_stb,
    input  logic               fall_stb,
    input  logic               mdio_i,
    output logic               busy,
    output logic               is_read,
    output logic               done,
    output logic [IDX_W-1:0]   bit_idx,
    output logic [REPLY_W-1:0] reply,
    output logic               mdio_o,
    output logic               mdio_oe
);

    logic [FRAME_W-1:0] frame_q;
    logic [IDX_W-1:0]   idx_q;
    logic [REPLY_W-1:0] rx_q;
    logic               busy_q;
    logic               rd_q;
    logic               o_q;
    logic               oe_q;
    logic               last_bit;
    logic [IDX_W-1:0]   idx_nxt;
    pin_drv_t           drv_nxt;

    // Next-position helpers for the falling-edge update.
    always_comb begin
        last_bit = (idx_q == IDX_W'(SEQ_LEN - 1));
        idx_nxt  = idx_q + IDX_W'(1);
        drv_nxt  = drive_for(idx_nxt, frame_q, rd_q);
    end

    // Sequence state, line drive and reply capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            rd_q    <= 1'b0;
            idx_q   <= '0;
            frame_q <= '0;
            rx_q    <= '0;
            o_q     <= 1'b1;
            oe_q    <= 1'b0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q  <= 1'b1;
                rd_q    <= (frame[OP_HI -: 2] == OP_READ);
                idx_q   <= '0;
                frame_q <= frame;
                rx_q    <= '0;
                o_q     <= 1'b1;
                oe_q    <= 1'b1;
            end
        end else if (rise_stb) begin
            if (rd_q && idx_q >= IDX_W'(DATA_START)) begin
                rx_q <= {rx_q[REPLY_W-2:0], mdio_i};
            end
        end else if (fall_stb) begin
            if (last_bit) begin
                busy_q <= 1'b0;
                o_q    <= 1'b1;
                oe_q   <= 1'b0;
            end else begin
                idx_q <= idx_nxt;
                o_q   <= drv_nxt.o;
                oe_q  <= drv_nxt.oe;
            end
        end
    end

    assign busy    = busy_q;
    assign is_read = rd_q;
    assign done    = busy_q && fall_stb && last_bit;
    assign bit_idx = idx_q;
    assign reply   = rx_q;
    assign mdio_o  = o_q;
    assign mdio_oe = oe_q;

endmodule

// File: rtl/mdio_csr.sv
// Register file: data word, completion event flag (write 1 to clear) and
// MDC speed. Issues the start pulse for a data write while idle and loads
// the read reply into the low half of the data word at completion.
// Assumes a single-cycle write strobe and a combinational read path.
module mdio_csr
    import mdio_mgmt_pkg::*;
#(
    parameter int SPD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [FRAME_W-1:0] wdata,
    input  logic               busy,
    input  logic               done,
    input  logic               is_read,
    input  logic [REPLY_W-1:0] reply,
    output logic               start,
    output logic [FRAME_W-1:0] data_word,
    output logic [SPD_W-1:0]   speed,
    output logic               evt,
    output logic [FRAME_W-1:0] rdata
);

    logic [FRAME_W-1:0] data_q;
    logic [SPD_W-1:0]   speed_q;
    logic               evt_q;

    // A data write starts a transaction only while the engine is idle.
    assign start = wr && (addr == ADR_DATA) && !busy;

    // Data word: loaded by an accepted write, low half replaced by a reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (start) begin
            data_q <= wdata;
        end else if (done && is_read) begin
            data_q[REPLY_W-1:0] <= reply;
        end
    end

    // Event flag: set on completion, cleared by writing 1; setting wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= 1'b0;
        end else if (done) begin
            evt_q <= 1'b1;
        end else if (wr && addr == ADR_EVENT && wdata[0]) begin
            evt_q <= 1'b0;
        end
    end

    // Speed register: plain read/write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            speed_q <= '0;
        end else if (wr && addr == ADR_SPEED) begin
            speed_q <= wdata[SPD_W-1:0];
        end
    end

    // Read multiplexer.
    always_comb begin
        unique case (addr)
            ADR_DATA:  rdata = data_q;
            ADR_EVENT: rdata = {{(FRAME_W-1){1'b0}}, evt_q};
            ADR_SPEED: rdata = {{(FRAME_W-SPD_W){1'b0}}, speed_q};
            default:   rdata = '0;
        endcase
    end

    assign data_word = data_q;
    assign speed     = speed_q;
    assign evt       = evt_q;

endmodule

// File: rtl/mdio_mgmt_master.sv
// Top level of the MDIO management master: connects the register file, the
// MDC generator and the frame engine. The MDIO pad is modelled as separate
// input, output and output-enable pins.
// Assumes the speed field width SPD_W is at most 32.
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int SPD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [FRAME_W-1:0] bus_wdata,
    output logic [FRAME_W-1:0] bus_rdata,
    output logic               mdc,
    input  logic               mdio_i,
    output logic               mdio_o,
    output logic               mdio_oe
);

    logic               start;
    logic               busy;
    logic               is_read;
    logic               done;
    logic               evt;
    logic               rise_stb;
    logic               fall_stb;
    logic [IDX_W-1:0]   bit_idx;
    logic [REPLY_W-1:0] reply;
    logic [FRAME_W-1:0] data_word;
    logic [SPD_W-1:0]   speed;

    mdio_csr #(.SPD_W(SPD_W)) csr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .busy      (busy),
        .done      (done),
        .is_read   (is_read),
        .reply     (reply),
        .start     (start),
        .data_word (data_word),
        .speed     (speed),
        .evt       (evt),
        .rdata     (bus_rdata)
    );

    mdio_mdc_gen #(.SPD_W(SPD_W)) mdc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .speed    (speed),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_engine eng_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .frame    (bus_wdata),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .is_read  (is_read),
        .done     (done),
        .bit_idx  (bit_idx),
        .reply    (reply),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

endmodule

// File: rtl/mdio_mgmt_master_chk.sv
// Checker: temporal properties of the MDIO management master, bound to the
// top module. Observes ports and the nets between the sub-blocks.
module mdio_mgmt_master_chk
    import mdio_mgmt_pkg::*;
#(
    parameter int SPD_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               mdc,
    input logic               mdio_o,
    input logic               mdio_oe,
    input logic               busy,
    input logic               done,
    input logic               is_read,
    input logic               evt,
    input logic [IDX_W-1:0]   bit_idx,
    input logic [FRAME_W-1:0] data_word,
    input logic [SPD_W-1:0]   speed
);

    AST_MDIO_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $stable(mdio_o)); // R4

    AST_READ_LINE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_read && bit_idx >= IDX_W'(RELEASE_AT)) |-> !mdio_oe); // R5

    AST_WRITE_LINE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !is_read) |-> mdio_oe); // R5

    AST_DONE_RAISES_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> evt); // R7

    AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe)); // R7

    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && bus_wr && bus_addr == ADR_DATA) |=> $stable(data_word)); // R8

    AST_ZERO_SPEED_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (speed == '0 && $past(speed) == '0) |-> $stable(mdc)); // R9

endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk #(.SPD_W(SPD_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .busy      (busy),
    .done      (done),
    .is_read   (is_read),
    .evt       (evt),
    .bit_idx   (bit_idx),
    .data_word (data_word),
    .speed     (speed)
);

// File: tb/mdio_mgmt_master_tb_top.sv
// Scoreboard bench: the driver pushes the expected 64-bit line pattern per
// transaction; the monitor collects line bits at rising MDC edges and
// compares them. A responder returns reply bits during read data phases.
module mdio_mgmt_master_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        mdc;
    logic        mdio_i;
    logic        mdio_o;
    logic        mdio_oe;

    int errors = 0;
    int checks = 0;

    logic [63:0] exp_o_q[$];
    logic [63:0] exp_oe_q[$];
    int          mon_cnt = 0;
    logic        rsp_read = 1'b0;
    logic        rsp_drive = 1'b0;
    logic [15:0] rsp_reply = 16'h0;
    int          edge_viol = 0;

    always #5 clk = ~clk;

    mdio_mgmt_master dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mdc       (mdc),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    // PHY responder: pulled high unless driving a reply (R6, R10).
    always_comb begin
        mdio_i = 1'b1;
        if (rsp_read && rsp_drive) begin
            if (mon_cnt == 47) mdio_i = 1'b0;
            else if (mon_cnt >= 48 && mon_cnt <= 63) mdio_i = rsp_reply[63 - mon_cnt];
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: one bit per rising MDC edge, compare after 64 bits (R3, R5).
    initial begin
        logic [63:0] got_o;
        logic [63:0] got_oe;
        logic [63:0] eo;
        logic [63:0] eoe;
        forever begin
            @(posedge mdc);
            got_o[63 - mon_cnt]  = mdio_o;
            got_oe[63 - mon_cnt] = mdio_oe;
            if (mon_cnt == 63) begin
                mon_cnt = 0;
                if (exp_o_q.size() == 0) begin
                    check("R3 unexpected frame", 64'd1, 64'd0);
                end else begin
                    eo  = exp_o_q.pop_front();
                    eoe = exp_oe_q.pop_front();
                    check("R3 line bits", got_o & eoe, eo & eoe);
                    check("R5 output enable pattern", got_oe, eoe);
                end
            end else begin
                mon_cnt = mon_cnt + 1;
            end
        end
    end

    // Edge watcher: MDIO output may only move when MDC falls (R4).
    initial begin
        logic pm;
        logic po;
        @(posedge rst_n);
        @(negedge clk);
        pm = mdc; po = mdio_o;
        forever begin
            @(negedge clk);
            if (mdio_o !== po && !(pm === 1'b1 && mdc === 1'b0)) edge_viol++;
            pm = mdc; po = mdio_o;
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_event();
        logic [31:0] r;
        for (int i = 0; i < 5000; i++) begin
            bus_read(2'd1, r);
            if (r[0]) return;
        end
        check("R7 completion timeout", 64'd0, 64'd1);
    endtask

    // Driver: push the expected pattern, set up responder, start the frame.
    task automatic start_txn(input logic [31:0] word, input logic drive, input logic [15:0] rep);
        logic rd;
        rd = (word[29:28] == 2'b10);
        exp_o_q.push_back({32'hFFFF_FFFF, word});
        exp_oe_q.push_back(rd ? ~64'h1_FFFF : ~64'h0);
        rsp_read  = rd;
        rsp_drive = drive;
        rsp_reply = rep;
        bus_write(2'd0, word);
    endtask

    function automatic logic [31:0] rd_word(input int phy, input int rg);
        return 32'h6002_0000 | (32'(phy) << 23) | (32'(rg) << 18);
    endfunction

    function automatic logic [31:0] wr_word(input int phy, input int rg, input logic [15:0] v);
        return 32'h5002_0000 | (32'(phy) << 23) | (32'(rg) << 18) | 32'(v);
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #1_500_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [31:0] w;
        time t1;
        time tf;
        time t2;
        logic m0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        @(negedge clk);
        check("R1 mdc", 64'(mdc), 64'd0);
        check("R1 mdio_oe", 64'(mdio_oe), 64'd0);
        check("R1 mdio_o", 64'(mdio_o), 64'd1);
        bus_read(2'd0, r); check("R1 data reg", 64'(r), 64'd0);
        bus_read(2'd1, r); check("R1 event reg", 64'(r), 64'd0);
        bus_read(2'd2, r); check("R1 speed reg", 64'(r), 64'd0);

        // R2: MDC timing at speed 3 during a write frame.
        bus_write(2'd2, 32'd3);
        w = wr_word(1, 4, 16'hA5C3);
        start_txn(w, 1'b0, 16'h0);
        @(posedge mdc); t1 = $time;
        @(negedge mdc); tf = $time;
        @(posedge mdc); t2 = $time;
        check("R2 mdc high time", 64'((tf - t1) / 10), 64'd3);
        check("R2 mdc period", 64'((t2 - t1) / 10), 64'd6);
        wait_event();
        bus_read(2'd0, r); check("R3 write keeps data reg", 64'(r), 64'(w));

        // R7: event flag clear semantics, line idle after completion.
        check("R7 mdc low after done", 64'(mdc), 64'd0);
        check("R7 oe low after done", 64'(mdio_oe), 64'd0);
        bus_write(2'd1, 32'd0);
        bus_read(2'd1, r); check("R7 write 0 keeps event", 64'(r[0]), 64'd1);
        bus_write(2'd1, 32'd1);
        bus_read(2'd1, r); check("R7 write 1 clears event", 64'(r[0]), 64'd0);

        // R6: read with PHY reply, speed 2.
        bus_write(2'd2, 32'd2);
        w = rd_word(5, 2);
        start_txn(w, 1'b1, 16'h1234);
        wait_event();
        bus_read(2'd0, r); check("R6 read reply in data reg", 64'(r), 64'({w[31:16], 16'h1234}));
        bus_write(2'd1, 32'd1);

        // R6: second reply pattern, speed 1.
        bus_write(2'd2, 32'd1);
        w = rd_word(31, 17);
        start_txn(w, 1'b1, 16'h8001);
        wait_event();
        bus_read(2'd0, r); check("R6 read reply edge bits", 64'(r), 64'({w[31:16], 16'h8001}));
        bus_write(2'd1, 32'd1);

        // R10: no PHY present, line stays high.
        w = rd_word(9, 1);
        start_txn(w, 1'b0, 16'h0);
        wait_event();
        bus_read(2'd0, r); check("R10 absent PHY reads all ones", 64'(r[15:0]), 64'hFFFF);
        bus_write(2'd1, 32'd1);

        // R8: data write during a frame is ignored.
        bus_write(2'd2, 32'd2);
        w = wr_word(2, 3, 16'h0F0F);
        start_txn(w, 1'b0, 16'h0);
        repeat (20) @(negedge clk);
        bus_write(2'd0, 32'hDEAD_BEEF);
        bus_read(2'd0, r); check("R8 busy write ignored (during)", 64'(r), 64'(w));
        wait_event();
        bus_read(2'd0, r); check("R8 busy write ignored (after)", 64'(r), 64'(w));
        bus_write(2'd1, 32'd1);

        // R9: zero speed pauses mid-frame, then resumes.
        w = rd_word(7, 30);
        start_txn(w, 1'b1, 16'h5AA5);
        repeat (90) @(negedge clk);
        bus_write(2'd2, 32'd0);
        @(negedge clk);
        m0 = mdc;
        repeat (60) @(negedge clk);
        check("R9 mdc frozen", 64'(mdc), 64'(m0));
        bus_read(2'd1, r); check("R9 no completion while paused", 64'(r[0]), 64'd0);
        bus_write(2'd2, 32'd2);
        wait_event();
        bus_read(2'd0, r); check("R9 resumed read reply", 64'(r), 64'({w[31:16], 16'h5AA5}));
        bus_write(2'd1, 32'd1);

        repeat (10) @(negedge clk);
        check("R3 all frames observed", 64'(exp_o_q.size()), 64'd0);
        check("R4 mdio moves only on falling mdc", 64'(edge_viol), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule